// File: doc/BRIEF.md
# Pipelined Bilinear Pixel Interpolator

This block computes one scaled output pixel from the four original pixels that surround the target position and from two fractional offsets. `dx` is the horizontal offset and `dy` is the vertical offset. It sits behind a prefilter and a pixel fetch unit. Those units supply, for every output position, the top-left, top-right, bottom-left and bottom-right neighbours together with the two offsets. A new pixel set may be presented on every clock.

The formula is nested rather than evaluated as four weighted terms. First, one vertical interpolation runs down the left column and another runs down the right column, both weighted by `dy`. Then a horizontal interpolation between those two results, weighted by `dx`, gives the output. This needs two multiplier stages and a few subtractors. The work is spread across four register stages, so results leave exactly four clocks after their inputs arrive, together with a matching valid strobe.

Offsets are unsigned fractions with `FRAC_W` fraction bits. A value of 0 selects the top or left pixel. The largest code stops one LSB short of the bottom or right pixel. Every scaled difference is rounded to the nearest integer by adding half an LSB and then shifting right arithmetically, which floors the result. The output is clamped to the pixel range.

Top module: `bilerp_pipe`

## Requirements
- R1: A sample accepted with `in_valid` high at a rising edge produces `out_valid` high exactly 4 rising edges later, and `out_valid` is low in every cycle that no accepted sample maps to.
- R2: When `dx` and `dy` are both 0, `out_pix` equals `tl` exactly.
- R3: `out_pix` = clamp(A + rnd(dx*(B-A))), where A = tl + rnd(dy*(bl-tl)) and B = tr + rnd(dy*(br-tr)). Here rnd(v) = floor((v + 2^(FRAC_W-1)) / 2^FRAC_W), and differences are signed.
- R4: With `dy` = 0 the output is a pure horizontal interpolation, tl + rnd(dx*(tr-tl)), and the bottom row has no effect.
- R5: With `dx` = 0 the output is a pure vertical interpolation, tl + rnd(dy*(bl-tl)), and the right column has no effect.
- R6: Samples presented on consecutive clocks each produce their own result on consecutive clocks, in input order.
- R7: While `rst_n` is low and after its release, before any sample has completed, `out_valid` is 0 and `out_pix` is 0.
- R8: Every result lies between the smallest and the largest of its four input pixels, both bounds included.
- R9: `out_pix` holds its previous value in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The input pixel set and offsets are valid this cycle |
| tl | input | PIX_W | Top-left neighbour, P(m,n) |
| tr | input | PIX_W | Top-right neighbour, P(m+1,n) |
| bl | input | PIX_W | Bottom-left neighbour, P(m,n+1) |
| br | input | PIX_W | Bottom-right neighbour, P(m+1,n+1) |
| dx | input | FRAC_W | Horizontal fractional offset |
| dy | input | FRAC_W | Vertical fractional offset |
| out_valid | output | 1 | The interpolated pixel is valid this cycle |
| out_pix | output | PIX_W | Interpolated pixel |

## Verification
The bench targets negative differences, for example a bright top row over a dark bottom row. A design that treated differences as unsigned would wrap these to large values far outside the neighbour range. Offsets of 0 and of all ones test the rounding: a missing half-LSB offset shifts many results down by one, and a truncating or logical shift corrupts negative products. Back-to-back traffic mixed with idle gaps tests the valid alignment and the holding of `out_pix`. A stage that dropped or repeated a register would deliver results in the wrong cycle or let the output drift while the strobe is low.

// File: rtl/bilerp_pipe.sv
module bilerp_pipe #(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  tl,
  input  logic [PIX_W-1:0]  tr,
  input  logic [PIX_W-1:0]  bl,
  input  logic [PIX_W-1:0]  br,
  input  logic [FRAC_W-1:0] dx,
  input  logic [FRAC_W-1:0] dy,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_pix
);

  localparam int SW = PIX_W + 3;
  localparam int PW = SW + FRAC_W + 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC_W - 1);
  localparam logic signed [SW-1:0] MAXV = SW'((1 << PIX_W) - 1);

  function automatic logic signed [SW-1:0] widen(input logic [PIX_W-1:0] p);
    return $signed({3'b000, p});
  endfunction

  function automatic logic signed [SW-1:0] scale(input logic signed [SW-1:0] d,
                                                  input logic [FRAC_W-1:0] f);
    logic signed [PW-1:0] prod;
    prod = d * $signed({1'b0, f});
    prod = prod + HALF;
    prod = prod >>> FRAC_W;
    return prod[SW-1:0];
  endfunction

  // stage 1: column differences
  logic                     s1_v;
  logic [PIX_W-1:0]         s1_tl, s1_tr;
  logic signed [SW-1:0]     s1_dl, s1_dr;
  logic [FRAC_W-1:0]        s1_dx, s1_dy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v  <= 1'b0;
      s1_tl <= '0;
      s1_tr <= '0;
      s1_dl <= '0;
      s1_dr <= '0;
      s1_dx <= '0;
      s1_dy <= '0;
    end else begin
      s1_v  <= in_valid;
      s1_tl <= tl;
      s1_tr <= tr;
      s1_dl <= widen(bl) - widen(tl);
      s1_dr <= widen(br) - widen(tr);
      s1_dx <= dx;
      s1_dy <= dy;
    end
  end

  // stage 2: vertical interpolation in both columns
  logic                     s2_v;
  logic signed [SW-1:0]     s2_a, s2_b;
  logic [FRAC_W-1:0]        s2_dx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v  <= 1'b0;
      s2_a  <= '0;
      s2_b  <= '0;
      s2_dx <= '0;
    end else begin
      s2_v  <= s1_v;
      s2_a  <= widen(s1_tl) + scale(s1_dl, s1_dy);
      s2_b  <= widen(s1_tr) + scale(s1_dr, s1_dy);
      s2_dx <= s1_dx;
    end
  end

  // stage 3: horizontal difference
  logic                     s3_v;
  logic signed [SW-1:0]     s3_a, s3_h;
  logic [FRAC_W-1:0]        s3_dx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s3_v  <= 1'b0;
      s3_a  <= '0;
      s3_h  <= '0;
      s3_dx <= '0;
    end else begin
      s3_v  <= s2_v;
      s3_a  <= s2_a;
      s3_h  <= s2_b - s2_a;
      s3_dx <= s2_dx;
    end
  end

  // stage 4: horizontal interpolation, clamp, output register
  logic signed [SW-1:0] res;
  logic [PIX_W-1:0]     res_c;

  assign res = s3_a + scale(s3_h, s3_dx);

  always_comb begin
    if (res < 0)          res_c = '0;
    else if (res > MAXV)  res_c = MAXV[PIX_W-1:0];
    else                  res_c = res[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= s3_v;
      if (s3_v) out_pix <= res_c;
    end
  end

endmodule

// File: rtl/bilerp_pipe_chk.sv
module bilerp_pipe_chk #(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [PIX_W-1:0]  tl,
  input logic [PIX_W-1:0]  tr,
  input logic [PIX_W-1:0]  bl,
  input logic [PIX_W-1:0]  br,
  input logic [FRAC_W-1:0] dx,
  input logic [FRAC_W-1:0] dy,
  input logic              out_valid,
  input logic [PIX_W-1:0]  out_pix
);

  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 4) since_rst <= since_rst + 3'd1;
  end

  logic [PIX_W-1:0] lo, hi, lo_t, hi_t, lo_b, hi_b;
  assign lo_t = (tl < tr) ? tl : tr;
  assign hi_t = (tl < tr) ? tr : tl;
  assign lo_b = (bl < br) ? bl : br;
  assign hi_b = (bl < br) ? br : bl;
  assign lo   = (lo_t < lo_b) ? lo_t : lo_b;
  assign hi   = (hi_t < hi_b) ? hi_b : hi_t;

  logic zero_off;
  assign zero_off = in_valid && dx == '0 && dy == '0;

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 4) |-> (out_valid == $past(in_valid, 4))); // R1

  AST_ZERO_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 4 && $past(zero_off, 4)) |-> (out_pix == $past(tl, 4))); // R2

  AST_WITHIN_NEIGHBOURS: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 4 && out_valid) |->
      (out_pix >= $past(lo, 4) && out_pix <= $past(hi, 4))); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 0 && !out_valid) |-> $stable(out_pix)); // R9

  AST_EARLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < 4) |-> (!out_valid && out_pix == '0)); // R7

endmodule

bind bilerp_pipe bilerp_pipe_chk #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .tl(tl), .tr(tr), .bl(bl), .br(br), .dx(dx), .dy(dy),
  .out_valid(out_valid), .out_pix(out_pix)
);

// File: tb/bilerp_pipe_tb.sv
`timescale 1ns/1ps
module bilerp_pipe_tb;

  localparam int PIX_W  = 8;
  localparam int FRAC_W = 8;
  localparam int MAXP   = (1 << PIX_W) - 1;
  localparam int MAXF   = (1 << FRAC_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [PIX_W-1:0] tl = '0, tr = '0, bl = '0, br = '0;
  logic [FRAC_W-1:0] dx = '0, dy = '0;
  logic out_valid;
  logic [PIX_W-1:0] out_pix;

  always #2.5 clk = ~clk;

  bilerp_pipe #(.PIX_W(PIX_W), .FRAC_W(FRAC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .tl(tl), .tr(tr), .bl(bl), .br(br), .dx(dx), .dy(dy),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  typedef struct {
    int    pix;
    int    cyc;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   cycle = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  bit   mon_on = 0;
  int   last_pix = 0;

  always @(posedge clk) cycle <= cycle + 1;

  function automatic int rnd(int v);
    return (v + (1 << (FRAC_W - 1))) >>> FRAC_W;
  endfunction

  function automatic int model(int a00, int a10, int a01, int a11, int fx, int fy);
    int a, b, r;
    a = a00 + rnd(fy * (a01 - a00));
    b = a10 + rnd(fy * (a11 - a10));
    r = a + rnd(fx * (b - a));
    if (r < 0) r = 0;
    if (r > MAXP) r = MAXP;
    return r;
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cycle);
    end
  endtask

  task automatic send(int a00, int a10, int a01, int a11, int fx, int fy, string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    tl = a00[PIX_W-1:0]; tr = a10[PIX_W-1:0];
    bl = a01[PIX_W-1:0]; br = a11[PIX_W-1:0];
    dx = fx[FRAC_W-1:0]; dy = fy[FRAC_W-1:0];
    e.pix = model(a00, a10, a01, a11, fx, fy);
    e.cyc = cycle + 4;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      tl = 8'hA5; tr = 8'h5A; bl = 8'hFF; br = 8'h00; dx = 8'h80; dy = 8'h40;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected out_valid", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(cycle == e.cyc, {"R1 latency ", e.tag}, cycle, e.cyc);
          check(int'(out_pix) == e.pix, e.tag, int'(out_pix), e.pix);
        end
        last_pix = int'(out_pix);
      end else begin
        check(int'(out_pix) == last_pix, "R9 hold while idle", int'(out_pix), last_pix);
        if (exp_q.size() != 0 && exp_q[0].cyc < cycle)
          check(1'b0, "R1 missing out_valid", 0, 1);
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    in_valid = 1'b1; tl = 8'd200; dx = 8'd0; dy = 8'd0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7 out_valid in reset", int'(out_valid), 0);
    check(out_pix == '0, "R7 out_pix in reset", int'(out_pix), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    idle(2);
    check(out_valid == 1'b0, "R7 out_valid after reset", int'(out_valid), 0);
    check(out_pix == '0, "R7 out_pix after reset", int'(out_pix), 0);
    mon_on = 1;

    // R2 zero offsets
    send(37, 250, 0, 255, 0, 0, "R2 zero offsets a");
    send(255, 0, 0, 0, 0, 0, "R2 zero offsets b");
    idle(6);
    // R4 horizontal only; bottom row differs wildly
    send(10, 200, 255, 0, 128, 0, "R4 horizontal mid");
    send(200, 10, 0, 255, 255, 0, "R4 horizontal falling");
    send(0, 255, 77, 3, 1, 0, "R4 horizontal min step");
    idle(3);
    // R5 vertical only; right column differs wildly
    send(20, 255, 220, 0, 0, 64, "R5 vertical quarter");
    send(255, 0, 0, 255, 0, 255, "R5 vertical falling max");
    send(100, 7, 101, 250, 0, 128, "R5 vertical half round");
    idle(5);
    // R3 full 2-D including negative differences and max offsets
    send(255, 255, 0, 0, 255, 255, "R3 bright over dark");
    send(0, 255, 255, 0, 128, 128, "R3 checker centre");
    send(255, 255, 255, 255, 255, 255, "R3 all white");
    send(12, 240, 99, 3, 77, 201, "R3 mixed");
    send(1, 0, 0, 0, 128, 128, "R3 round tie");
    idle(6);
    // R6 back-to-back random traffic, R8 bound checked via model
    for (int i = 0; i < 300; i++) begin
      send($urandom_range(0, MAXP), $urandom_range(0, MAXP),
           $urandom_range(0, MAXP), $urandom_range(0, MAXP),
           $urandom_range(0, MAXF), $urandom_range(0, MAXF), "R6 R3 back-to-back");
    end
    // mixed gaps
    for (int i = 0; i < 200; i++) begin
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 5));
      send($urandom_range(0, MAXP), $urandom_range(0, MAXP),
           $urandom_range(0, MAXP), $urandom_range(0, MAXP),
           $urandom_range(0, MAXF), $urandom_range(0, MAXF), "R1 R8 gapped");
    end
    idle(10);
    check(exp_q.size() == 0, "R1 all results delivered", exp_q.size(), 0);
    done = 1;
    finish_run();
  end

endmodule